// File: doc/BRIEF.md
# Buffer Pool Allocation Controller

This block keeps track of which entries of a fixed pool of buffers are in use. A client that needs a buffer raises the allocate request and, in the same cycle, reads the index of the lowest-numbered idle buffer. A client that is done with a buffer raises the release request with that buffer's index. One busy flag per buffer and a running count of busy buffers make up all of the block's state. The buffers themselves and their data paths live outside.

When every buffer is taken, an allocate request is refused with a negative acknowledge, and the index output carries no meaning. An allocation and a release may land on the same buffer in the same cycle; the allocation takes effect and the buffer stays busy. A release aimed at an idle buffer changes nothing.

Top module: `buf_pool_alloc`

## Requirements
- R1: After reset every buffer is idle and the busy count is zero, so alloc_addr_o reads 0 and 32 consecutive allocations succeed.
- R2: While at least one buffer is idle, alloc_addr_o equals the smallest index whose busy flag is clear, combinationally from the current flags.
- R3: nack_o is 1 exactly when alloc_i is 1 and the busy count equals the pool size (32). It is 0 whenever alloc_i is 0.
- R4: An allocation that is not refused marks buffer alloc_addr_o busy at the next clock edge. That buffer is not handed out again until it has been released.
- R5: A release with free_i=1 to a busy buffer free_addr_i clears its busy flag and lowers the count by one at the next edge, so the buffer becomes allocatable again.
- R6: A release to a buffer that is already idle leaves every busy flag and the count unchanged.
- R7: When a granted allocation and a release name the same buffer in one cycle, the buffer ends up busy and the count rises by one.
- R8: The busy count always equals the number of set busy flags, including when one buffer is released and a different one is allocated in the same cycle, or when a release arrives during a refused allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocation request |
| nack_o | output | 1 | Allocation refused, pool full |
| alloc_addr_o | output | 5 | Index of lowest idle buffer (meaningless while full) |
| free_i | input | 1 | Release request |
| free_addr_i | input | 5 | Index of buffer being released |

## Verification
On every cycle the assertions check the following: the refusal occurs exactly when all flags are set; the offered index is idle and every lower one is busy; a grant leaves its buffer busy; a release to a busy buffer clears it and decrements the count; an idle release changes nothing; the count matches the population of the flags. Some behaviour is visible only in the bench's scenarios. These are the full fill order from reset, the exact cycle where the refusal begins after long mixed traffic, and a release during a refused allocation freeing a slot that the next request receives. The bench shows them by comparing the ports against a model of the flags that it keeps itself.

// File: rtl/buf_pool_pkg.sv
package buf_pool_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/buf_lowest_free.sv
module buf_lowest_free #(
  parameter int unsigned NUM_BUFS = 32,
  parameter int unsigned AW       = 5
) (
  input  logic [NUM_BUFS-1:0] busy_i,
  output logic                any_free_o,
  output logic [AW-1:0]       addr_o
);
  // scan high to low so the lowest idle index is written last
  always_comb begin
    addr_o     = '0;
    any_free_o = 1'b0;
    for (int i = NUM_BUFS - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        addr_o     = AW'(i);
        any_free_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/buf_busy_bits.sv
module buf_busy_bits #(
  parameter int unsigned NUM_BUFS = 32,
  parameter int unsigned AW       = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [AW-1:0]       set_addr_i,
  input  logic                clr_en_i,
  input  logic [AW-1:0]       clr_addr_i,
  output logic [NUM_BUFS-1:0] busy_o,
  output logic                clr_hit_o
);
  logic [NUM_BUFS-1:0] set_sel;
  logic [NUM_BUFS-1:0] clr_sel;

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_bit
    assign set_sel[g] = set_en_i && (set_addr_i == AW'(g));
    assign clr_sel[g] = clr_en_i && (clr_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         busy_o[g] <= 1'b0;
      else if (set_sel[g]) busy_o[g] <= 1'b1;  // allocation wins
      else if (clr_sel[g]) busy_o[g] <= 1'b0;
    end
  end

  // release counts only if the addressed buffer is busy now
  assign clr_hit_o = |(clr_sel & busy_o);
endmodule

// File: rtl/buf_busy_count.sv
module buf_busy_count #(
  parameter int unsigned NUM_BUFS = 32,
  parameter int unsigned CW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   count_o <= count_o + CW'(1);
        2'b01:   count_o <= count_o - CW'(1);
        default: count_o <= count_o;
      endcase
    end
  end

  assign full_o = (count_o == CW'(NUM_BUFS));
endmodule

// File: rtl/buf_pool_alloc.sv
module buf_pool_alloc
  import buf_pool_pkg::*;
#(
  parameter int unsigned NUM_BUFS = 32,
  localparam int unsigned AW      = idx_width(NUM_BUFS),
  localparam int unsigned CW      = cnt_width(NUM_BUFS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  output logic          nack_o,
  output logic [AW-1:0] alloc_addr_o,
  input  logic          free_i,
  input  logic [AW-1:0] free_addr_i
);
  logic [NUM_BUFS-1:0] busy_w;
  logic [CW-1:0]       count_w;
  logic                full_w;
  logic                any_free_w;
  logic                grant_w;
  logic                free_hit_w;

  assign nack_o  = alloc_i && full_w;
  assign grant_w = alloc_i && !full_w;

  buf_lowest_free #(.NUM_BUFS(NUM_BUFS), .AW(AW)) u_find (
    .busy_i     (busy_w),
    .any_free_o (any_free_w),
    .addr_o     (alloc_addr_o)
  );

  buf_busy_bits #(.NUM_BUFS(NUM_BUFS), .AW(AW)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (grant_w),
    .set_addr_i (alloc_addr_o),
    .clr_en_i   (free_i),
    .clr_addr_i (free_addr_i),
    .busy_o     (busy_w),
    .clr_hit_o  (free_hit_w)
  );

  buf_busy_count #(.NUM_BUFS(NUM_BUFS), .CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (grant_w),
    .dec_i   (free_hit_w),
    .count_o (count_w),
    .full_o  (full_w)
  );
endmodule

// File: rtl/buf_pool_alloc_chk.sv
module buf_pool_alloc_chk #(
  parameter int unsigned NUM_BUFS = 32,
  parameter int unsigned AW       = 5,
  parameter int unsigned CW       = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                alloc_i,
  input logic                nack_o,
  input logic [AW-1:0]       alloc_addr_o,
  input logic                free_i,
  input logic [AW-1:0]       free_addr_i,
  input logic [NUM_BUFS-1:0] busy_w,
  input logic [CW-1:0]       count_w,
  input logic                any_free_w
);
  logic [NUM_BUFS-1:0] below_mask;
  logic                granted;
  assign below_mask = (NUM_BUFS'(1) << alloc_addr_o) - NUM_BUFS'(1);
  assign granted    = alloc_i && !nack_o;

  // R3
  nack_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o == (alloc_i && (&busy_w)));
  // R3
  no_free_means_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free_w == !(&busy_w));
  // R8
  count_matches_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_w) == $countones(busy_w));
  // R2
  lowest_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted |-> (!busy_w[alloc_addr_o] && ((busy_w & below_mask) == below_mask)));
  // R4
  grant_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted |=> busy_w[$past(alloc_addr_o)]);
  // R5
  release_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i && busy_w[free_addr_i] && !granted) |=>
      (!busy_w[$past(free_addr_i)] && count_w == $past(count_w) - CW'(1)));
  // R6
  idle_release_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i && !busy_w[free_addr_i] && !alloc_i) |=> ($stable(busy_w) && $stable(count_w)));
  // R7
  alloc_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted && free_i && free_addr_i == alloc_addr_o) |=>
      (busy_w[$past(free_addr_i)] && count_w == $past(count_w) + CW'(1)));
endmodule

bind buf_pool_alloc buf_pool_alloc_chk #(.NUM_BUFS(NUM_BUFS), .AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alloc_i      (alloc_i),
  .nack_o       (nack_o),
  .alloc_addr_o (alloc_addr_o),
  .free_i       (free_i),
  .free_addr_i  (free_addr_i),
  .busy_w       (busy_w),
  .count_w      (count_w),
  .any_free_w   (any_free_w)
);

// File: tb/tb_buf_pool_alloc.sv
`timescale 1ns/1ps
module tb_buf_pool_alloc;
  localparam int N  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc = 1'b0;
  logic          free = 1'b0;
  logic [AW-1:0] free_addr = '0;
  logic          nack;
  logic [AW-1:0] alloc_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit m_busy [N];
  int m_count;

  always #10 clk = ~clk;  // 50 MHz

  buf_pool_alloc dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .alloc_i      (alloc),
    .nack_o       (nack),
    .alloc_addr_o (alloc_addr),
    .free_i       (free),
    .free_addr_i  (free_addr)
  );

  function automatic int lowest();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, update model after edge
  task automatic step(input bit a, input bit f, input int fa, input string tag);
    bit full;
    int ga;
    @(negedge clk);
    alloc = a; free = f; free_addr = AW'(fa);
    #2;
    full = (m_count == N);
    check(nack == (a && full), {tag, " nack"}, int'(nack), int'(a && full));
    if (!full) check(int'(alloc_addr) == lowest(), {tag, " addr"}, int'(alloc_addr), lowest());
    ga = lowest();
    @(posedge clk);
    #1;
    if (f) m_busy[fa] = 1'b0;
    if (a && !full) m_busy[ga] = 1'b1;
    m_count = 0;
    for (int i = 0; i < N; i++) m_count += int'(m_busy[i]);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 0, "idle");
  endtask

  initial begin
    bit [15:0] lfsr;
    for (int i = 0; i < N; i++) m_busy[i] = 1'b0;
    m_count = 0;
    #35;
    // R1: reset state seen at ports
    check(alloc_addr == '0, "R1 reset addr", int'(alloc_addr), 0);
    check(nack == 1'b0, "R1 reset nack", int'(nack), 0);
    rst_n = 1'b1;

    // R1 R2 R4: fill from empty in ascending order
    for (int i = 0; i < N; i++) step(1'b1, 1'b0, 0, "R1 fill");
    // R3: refused while full, no refusal without request
    step(1'b1, 1'b0, 0, "R3 full");
    step(1'b0, 1'b0, 0, "R3 noreq");

    // R5: release each busy buffer, next allocation returns it
    for (int k = 0; k < N; k++) begin
      step(1'b0, 1'b1, k, "R5 release");
      step(1'b1, 1'b0, 0, "R5 realloc");
      step(1'b1, 1'b0, 0, "R5 full again");
    end

    // R8: release during a refused allocation frees the slot
    step(1'b1, 1'b1, 7, "R8 refused+release");
    step(1'b1, 1'b0, 0, "R8 gets 7");
    step(1'b1, 1'b0, 0, "R8 full");

    // R7: same buffer freed and allocated in one cycle
    step(1'b0, 1'b1, 3, "R7 prep");
    step(1'b0, 1'b1, 9, "R7 prep");
    step(1'b1, 1'b1, 3, "R7 same addr");
    step(1'b1, 1'b0, 0, "R7 next is 9");
    step(1'b1, 1'b0, 0, "R7 full");

    // R6: releases to idle buffers change nothing
    step(1'b0, 1'b1, 20, "R6 prep");
    step(1'b0, 1'b1, 20, "R6 idle release");
    step(1'b0, 1'b1, 20, "R6 idle release");
    step(1'b1, 1'b0, 0, "R6 gets 20");
    step(1'b1, 1'b0, 0, "R6 full");

    // R8: release one, allocate another in the same cycle
    step(1'b0, 1'b1, 12, "R8 prep");
    step(1'b0, 1'b1, 13, "R8 prep");
    step(1'b1, 1'b1, 30, "R8 swap");
    step(1'b1, 1'b0, 0, "R8 swap next");
    step(1'b1, 1'b0, 0, "R8 swap next");
    step(1'b1, 1'b0, 0, "R8 swap full");

    // mixed traffic sweep
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | (lfsr[2] & lfsr[4]), int'(lfsr[9:5]), "R2 R8 sweep");
    end
    // drain then refill to confirm count tracking
    for (int k = 0; k < N; k++) step(1'b0, 1'b1, k, "R5 drain");
    for (int i = 0; i < N; i++) step(1'b1, 1'b0, 0, "R8 refill");
    step(1'b1, 1'b0, 0, "R3 end full");
    idle();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule